// File: doc/BRIEF.md
# Flash Read Wait-State Sequencer

This block times a single read of an on-chip flash array. It starts when a request is accepted and ends when the read word is returned. A request comes from one of four bus ports or from an internal CRC engine. Port 0 is the processor port.

For a bus port, an optional address-setup clock can be placed ahead of the arbitration request. The CRC engine never gets this setup clock. After the arbiter grants the request, the block strobes the array and then counts the access delay. The delay comes either from a programmed wait count or, in automatic mode, from a ready pulse on an external timing input. In automatic mode, every source other than port 0 is charged one further clock. The array is modelled as a small register file whose contents are fixed at reset.

The configuration inputs are captured at the moment a request is accepted. This means a change to them only affects the next read, never the read in progress.

Top module: `flash_ws_seq`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `arb_req`, `flash_strobe` and `rd_valid` are 0, and `rd_data` is 0.
- R2: A request from a bus port (`req_src` 0 to 3) with `cfg_addr_setup`=1 has one clock between acceptance and `arb_req`. With `cfg_addr_setup`=0 there is none.
- R3: A request from the CRC engine (`req_src`=4) never gets the setup clock, whatever `cfg_addr_setup` holds.
- R4: `arb_req` stays high until `arb_grant` is sampled high. `flash_strobe` is high for exactly the one clock that follows the grant, and `arb_req` is low from then on.
- R5: With `cfg_auto`=0 and the grant already high, `rd_valid` rises 2+S+W clocks after the clock edge that accepts the request. S is 1 when the setup clock applies, and W is `cfg_wait` (0 to 15).
- R6: With `cfg_auto`=1, `cfg_wait` is ignored. The access stays open until `auto_ready` is sampled high after the strobe clock, and a pulse on `auto_ready` before that is ignored. For port 0, `rd_valid` rises on the clock after that sample.
- R7: In automatic mode, every source other than port 0 (ports 1 to 3 and the CRC engine) gets one more clock before `rd_valid`.
- R8: `cfg_addr_setup`, `cfg_wait` and `cfg_auto` are captured when a request is accepted. Changing them during an access has no effect on that access.
- R9: `rd_valid` is high for exactly one clock, and the block is idle on the next clock. While `rd_valid` is high, `rd_data` equals the word at `req_addr`, where word(a) = (a*16'h0101) XOR 16'hA5C3 (lower 16 bits).
- R10: A `req_valid` pulse that arrives while an access is in progress is ignored. It does not start a new access and does not change the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-clock request pulse, taken only when idle |
| req_src | input | 3 | Source: 0 to 3 are bus ports (0 is the processor), 4 is the CRC engine |
| req_addr | input | 4 | Word address |
| cfg_addr_setup | input | 1 | Adds one address-setup clock for bus ports |
| cfg_wait | input | 4 | Programmed access wait count |
| cfg_auto | input | 1 | Selects automatic timing instead of the programmed count |
| auto_ready | input | 1 | Flash-ready pulse used in automatic mode |
| arb_grant | input | 1 | Grant from the arbiter |
| arb_req | output | 1 | Request to the arbiter |
| flash_strobe | output | 1 | One-clock array access strobe |
| rd_valid | output | 1 | One-clock read-data valid |
| rd_data | output | 16 | Read word, zero when not valid |

## Verification
With the grant held high, `arb_req` comes one clock after acceptance, or two clocks when the setup clock applies. `flash_strobe` follows one clock after the grant is sampled. `rd_valid` arrives 2+S+W clocks after acceptance in programmed mode, and 2+S+X clocks in automatic mode with `auto_ready` held high, where X=1 for sources other than port 0. The bench keeps a free-running count of clock edges and records the edge that accepts each request. It then samples every output on the falling edge, so the measured latency is the difference between the two edge counts. Each expected value comes from these formulas, plus the grant delay or ready delay that a directed test imposes.

// File: rtl/flash_ws_seq.sv
module flash_ws_seq #(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int NPORTS = 4,
  parameter int SRC_W  = 3,
  parameter int CW     = 4,
  parameter logic [DW-1:0] SEED = 16'hA5C3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SRC_W-1:0] req_src,
  input  logic [AW-1:0]    req_addr,
  input  logic             cfg_addr_setup,
  input  logic [CW-1:0]    cfg_wait,
  input  logic             cfg_auto,
  input  logic             auto_ready,
  input  logic             arb_grant,
  output logic             arb_req,
  output logic             flash_strobe,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [SRC_W-1:0] CRC_ID = SRC_W'(NPORTS);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ARB, S_ACC, S_EXTRA, S_DONE} st_t;

  st_t              st;
  logic [SRC_W-1:0] src_q;
  logic [AW-1:0]    addr_q;
  logic             auto_q;
  logic [CW-1:0]    cnt;
  logic             strobe_q;
  logic [DW-1:0]    data_q;
  logic [DW-1:0]    mem [DEPTH];
  logic             idle;

  assign idle         = (st == S_IDLE);
  assign arb_req      = (st == S_ARB);
  assign rd_valid     = (st == S_DONE);
  assign flash_strobe = strobe_q;
  assign rd_data      = rd_valid ? data_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      src_q    <= '0;
      addr_q   <= '0;
      auto_q   <= 1'b0;
      cnt      <= '0;
      strobe_q <= 1'b0;
      data_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= SEED ^ DW'(i * 257);
    end else begin
      strobe_q <= (st == S_ARB) && arb_grant;
      unique case (st)
        S_IDLE: if (req_valid) begin
          src_q  <= req_src;
          addr_q <= req_addr;
          auto_q <= cfg_auto;
          cnt    <= cfg_wait;
          st     <= (cfg_addr_setup && req_src != CRC_ID) ? S_SETUP : S_ARB;
        end
        S_SETUP: st <= S_ARB;
        S_ARB: if (arb_grant) begin
          data_q <= mem[addr_q];
          st     <= S_ACC;
        end
        S_ACC: begin
          if (auto_q) begin
            if (auto_ready) st <= (src_q != '0) ? S_EXTRA : S_DONE;
          end else if (cnt == '0) begin
            st <= S_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_EXTRA: st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_ws_seq_chk #(
  parameter int SRC_W = 3,
  parameter logic [SRC_W-1:0] CRC_ID = 3'd4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle,
  input logic             req_valid,
  input logic [SRC_W-1:0] req_src,
  input logic             cfg_addr_setup,
  input logic             arb_req,
  input logic             arb_grant,
  input logic             flash_strobe,
  input logic             rd_valid
);
  p_setup_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid && cfg_addr_setup && req_src != CRC_ID |=> !arb_req ##1 arb_req);

  p_direct_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid && (req_src == CRC_ID || !cfg_addr_setup) |=> arb_req);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req && !arb_grant |=> arb_req);

  p_strobe_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_strobe |-> $past(arb_req && arb_grant));

  p_phase_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_req, flash_strobe, rd_valid}));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid && idle);
endmodule

bind flash_ws_seq flash_ws_seq_chk #(.SRC_W(SRC_W), .CRC_ID(CRC_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .req_valid(req_valid), .req_src(req_src),
  .cfg_addr_setup(cfg_addr_setup), .arb_req(arb_req), .arb_grant(arb_grant),
  .flash_strobe(flash_strobe), .rd_valid(rd_valid)
);

// File: tb/flash_ws_seq_bench.sv
`timescale 1ns/1ps
module flash_ws_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, req_valid = 1'b0, cfg_addr_setup = 1'b0, cfg_auto = 1'b0;
  logic        auto_ready = 1'b0, arb_grant = 1'b1;
  logic [2:0]  req_src = '0;
  logic [3:0]  req_addr = '0, cfg_wait = '0;
  logic        arb_req, flash_strobe, rd_valid;
  logic [15:0] rd_data;

  flash_ws_seq u_flash_ws_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src), .req_addr(req_addr),
    .cfg_addr_setup(cfg_addr_setup), .cfg_wait(cfg_wait), .cfg_auto(cfg_auto),
    .auto_ready(auto_ready), .arb_grant(arb_grant), .arb_req(arb_req),
    .flash_strobe(flash_strobe), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  // {src[2:0], setup, auto}
  localparam logic [4:0] VEC [8] = '{
    5'b000_0_0, 5'b000_1_0, 5'b010_1_0, 5'b100_1_0,
    5'b000_1_1, 5'b011_0_1, 5'b100_1_1, 5'b001_1_1
  };

  function automatic logic [15:0] word(input int a);
    return 16'hA5C3 ^ 16'(a * 257);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic launch(input int src, input bit setup, input bit au, input int w,
                        input int addr, output int t0);
    @(negedge clk);
    req_src = 3'(src); cfg_addr_setup = setup; cfg_auto = au;
    cfg_wait = 4'(w); req_addr = 4'(addr); req_valid = 1'b1;
    t0 = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_valid(input int t0, output int lat, output int data);
    lat = -1; data = -1;
    for (int k = 0; k < 300; k++) begin
      if (rd_valid) begin lat = cyc - t0; data = int'(rd_data); break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int t0, lat, data, s, exp;
    string tag;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {arb_req, flash_strobe, rd_valid}, 0);
    chk("R1", "data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {arb_req, flash_strobe, rd_valid}, 0);

    for (int v = 0; v < 8; v++) begin
      for (int w = 0; w < 16; w++) begin
        int src; bit st_b, au;
        src = int'(VEC[v][4:2]); st_b = VEC[v][1]; au = VEC[v][0];
        auto_ready = au;
        launch(src, st_b, au, w, (w + v) % 16, t0);
        wait_valid(t0, lat, data);
        s = (st_b && src != 4) ? 1 : 0;
        if (au) begin
          exp = 2 + s + ((src != 0) ? 1 : 0);
          tag = (src != 0) ? "R7" : "R6";
        end else begin
          exp = 2 + s + w;
          tag = (src == 4) ? "R3" : (st_b ? "R2" : "R5");
        end
        chk(tag, $sformatf("latency v=%0d w=%0d", v, w), lat, exp);
        chk("R9", "read word", data, int'(word((w + v) % 16)));
        @(negedge clk);
        chk("R9", "valid one cycle", int'(rd_valid), 0);
      end
    end
    auto_ready = 1'b0;

    // R4: grant withheld
    arb_grant = 1'b0;
    launch(1, 1, 0, 2, 7, t0);
    chk("R2", "no req in setup clock", int'(arb_req), 0);
    @(negedge clk);
    chk("R4", "req raised", int'(arb_req), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4", "req held without grant", {arb_req, flash_strobe}, 2);
    end
    arb_grant = 1'b1;
    @(negedge clk);
    chk("R4", "strobe after grant, req dropped", {arb_req, flash_strobe}, 1);
    @(negedge clk);
    chk("R4", "strobe one cycle", int'(flash_strobe), 0);
    wait_valid(t0, lat, data);
    chk("R4", "latency with grant delay", lat, 8);
    chk("R9", "read word after delay", data, int'(word(7)));

    // R6: early ready ignored, delayed ready
    @(negedge clk);
    auto_ready = 1'b1;
    launch(0, 0, 1, 15, 3, t0);
    @(negedge clk);
    auto_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6", "waiting for ready", int'(rd_valid), 0);
    auto_ready = 1'b1;
    @(negedge clk);
    auto_ready = 1'b0;
    wait_valid(t0, lat, data);
    chk("R6", "latency set by ready pulse", lat, 6);

    // R8: config change mid-access
    @(negedge clk);
    launch(0, 0, 0, 3, 11, t0);
    cfg_wait = 4'd0; cfg_auto = 1'b1; cfg_addr_setup = 1'b1;
    wait_valid(t0, lat, data);
    chk("R8", "latency uses captured config", lat, 5);
    chk("R8", "read word", data, int'(word(11)));

    // R10: request while busy
    @(negedge clk);
    launch(2, 0, 0, 4, 5, t0);
    @(negedge clk);
    req_src = 3'd0; req_addr = 4'd9; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_valid(t0, lat, data);
    chk("R10", "latency unchanged", lat, 6);
    chk("R10", "data of first request", data, int'(word(5)));
    begin
      int extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (rd_valid || arb_req) extra++;
      end
      chk("R10", "no second access", extra, 0);
    end

    finish_run();
  end
endmodule